// File: doc/BRIEF.md
# Speculative Operand Address and Fetch Unit

This unit is the operand-fetch stage of a small 8-bit processor that has a zero page, an X and a Y index register and a stack page. It takes the two operand bytes of the current instruction, the index and stack registers and a mode code. In the issue cycle it builds every direct address the instruction could use and presents all of them to memory at once: zero page, zero page plus X, zero page plus Y, absolute, absolute plus X, absolute plus Y and stack plus one. It also requests the second byte of the two zero-page pointers that may be needed.

When the memory answers one cycle later, the zero-page and zero-page-plus-X results serve as 16-bit pointers. A second stage uses them to fetch the three possible indirect operands: the pointer at zp, the pointer at zp plus X, and the pointer at zp with Y added afterwards. The mode code picks the result. Direct and immediate operands come out on one channel one cycle after issue. Indirect operands come out on a second channel two cycles after issue. If the previous instruction is still writing X or Y, the forwarded value is used in place of the register value, and no stall is needed.

The attached memory is synchronous with one cycle of read latency on every port. It returns the byte at each presented address on the next clock.

Top module: `spec_operand_fetch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dir_vld` and `ind_vld` are 0.
- R2: Mode 0 (immediate): one cycle after issue, `dir_vld`=1, `dir_data` equals the issued `opnd_lo`, and `dir_addr` is 0x0000.
- R3: Modes 1, 2 and 3 (zero page, zero page plus X, zero page plus Y) read address {0x00, (lo + idx) mod 256}, where idx is 0, X or Y. The result on the direct channel carries that address and the byte stored there.
- R4: Modes 4, 5 and 6 (absolute, absolute plus X, absolute plus Y) read ({hi,lo} + idx) mod 65536. The result carries that address and its byte.
- R5: Mode 7 (stack) reads 0x0100 | ((SP + 1) mod 256).
- R6: Mode 8 ((zp)) uses the pointer whose low byte is at zp and whose high byte is at (zp + 1) mod 256. The result carries the pointer as its address and the byte at the pointer.
- R7: Mode 9 ((zp,X)) uses the pointer whose low byte is at (zp + X) mod 256 and whose high byte is at (zp + X + 1) mod 256.
- R8: Mode 10 ((zp),Y) uses (pointer at zp + Y) mod 65536, with Y added to the full 16-bit pointer.
- R9: When `x_fwd_vld` or `y_fwd_vld` is 1 in the issue cycle, `x_fwd` or `y_fwd` replaces `x_reg` or `y_reg` in every address that uses that index.
- R10: Modes 0 to 7 give `dir_vld` exactly one cycle after issue and no `ind_vld`. Modes 8 to 10 give `ind_vld` exactly two cycles after issue and no `dir_vld`. Modes 11 to 15 give neither.
- R11: An indirect issue followed at once by a direct issue produces both results in the same cycle, each correct on its own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction operands valid this cycle |
| mode | input | 4 | Addressing mode code (see R2 to R10) |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| x_reg | input | 8 | X register |
| y_reg | input | 8 | Y register |
| sp_reg | input | 8 | Stack pointer |
| x_fwd_vld | input | 1 | New X value being written this cycle |
| x_fwd | input | 8 | Forwarded X value |
| y_fwd_vld | input | 1 | New Y value being written this cycle |
| y_fwd | input | 8 | Forwarded Y value |
| dir_rd_addr | output | 112 | Seven direct read addresses: zp, zp+X, zp+Y, abs, abs+X, abs+Y, stack (slot 0 lowest) |
| dir_rd_data | input | 56 | Bytes returned for the direct addresses, one cycle later |
| ptr_rd_addr | output | 32 | Pointer high-byte addresses for zp and zp+X |
| ptr_rd_data | input | 16 | Bytes returned for the pointer high-byte addresses |
| ind_rd_addr | output | 48 | Indirect addresses: (zp), (zp,X), (zp),Y |
| ind_rd_data | input | 24 | Bytes returned for the indirect addresses |
| dir_vld | output | 1 | Direct or immediate result valid |
| dir_addr | output | 16 | Effective address of the direct result |
| dir_data | output | 8 | Direct or immediate operand |
| ind_vld | output | 1 | Indirect result valid |
| ind_addr | output | 16 | Effective address of the indirect result |
| ind_data | output | 8 | Indirect operand |

## Verification
The direct channel and the indirect channel can both be active in the same cycle. This happens when an indirect mode is issued and a direct mode follows on the very next clock, because the first result needs a second stage while the second needs only one. The bench provokes it with that back-to-back pair, choosing operands and index values that differ between the two. It checks that both valid flags are high together and that each channel's address and data match the memory model for its own instruction. The pair is also run with forwarding active on the second issue. This shows that the forwarded value reaches the new direct address while the stage-two Y already stored for the indirect instruction is left alone.

// File: rtl/spec_operand_fetch.sv
module spec_operand_fetch #(
  parameter int DW = 8,
  localparam int AW = 2 * DW,
  localparam int NDIR = 7,
  localparam int NPTR = 2,
  localparam int NIND = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue,
  input  logic [3:0]           mode,
  input  logic [DW-1:0]        opnd_lo,
  input  logic [DW-1:0]        opnd_hi,
  input  logic [DW-1:0]        x_reg,
  input  logic [DW-1:0]        y_reg,
  input  logic [DW-1:0]        sp_reg,
  input  logic                 x_fwd_vld,
  input  logic [DW-1:0]        x_fwd,
  input  logic                 y_fwd_vld,
  input  logic [DW-1:0]        y_fwd,
  output logic [NDIR*AW-1:0]   dir_rd_addr,
  input  logic [NDIR*DW-1:0]   dir_rd_data,
  output logic [NPTR*AW-1:0]   ptr_rd_addr,
  input  logic [NPTR*DW-1:0]   ptr_rd_data,
  output logic [NIND*AW-1:0]   ind_rd_addr,
  input  logic [NIND*DW-1:0]   ind_rd_data,
  output logic                 dir_vld,
  output logic [AW-1:0]        dir_addr,
  output logic [DW-1:0]        dir_data,
  output logic                 ind_vld,
  output logic [AW-1:0]        ind_addr,
  output logic [DW-1:0]        ind_data
);

  localparam logic [DW-1:0] ZPAGE = '0;
  localparam logic [DW-1:0] SPAGE = DW'(1);

  logic [DW-1:0] xe, ye, zpx, zpy, sp1;
  logic [AW-1:0] absa;
  logic          is_dir, is_ind;

  assign xe     = x_fwd_vld ? x_fwd : x_reg;
  assign ye     = y_fwd_vld ? y_fwd : y_reg;
  assign zpx    = opnd_lo + xe;
  assign zpy    = opnd_lo + ye;
  assign sp1    = sp_reg + DW'(1);
  assign absa   = {opnd_hi, opnd_lo};
  assign is_dir = ~mode[3];
  assign is_ind = mode[3] & (mode[2:0] <= 3'd2);

  assign dir_rd_addr[0*AW +: AW] = {ZPAGE, opnd_lo};
  assign dir_rd_addr[1*AW +: AW] = {ZPAGE, zpx};
  assign dir_rd_addr[2*AW +: AW] = {ZPAGE, zpy};
  assign dir_rd_addr[3*AW +: AW] = absa;
  assign dir_rd_addr[4*AW +: AW] = absa + {ZPAGE, xe};
  assign dir_rd_addr[5*AW +: AW] = absa + {ZPAGE, ye};
  assign dir_rd_addr[6*AW +: AW] = {SPAGE, sp1};

  assign ptr_rd_addr[0*AW +: AW] = {ZPAGE, opnd_lo + DW'(1)};
  assign ptr_rd_addr[1*AW +: AW] = {ZPAGE, zpx + DW'(1)};

  logic          s1_dir, s1_ind;
  logic [2:0]    s1_sel;
  logic [1:0]    s1_isel;
  logic [DW-1:0] s1_imm, s1_ye;
  logic [AW-1:0] s1_addr;
  logic [AW-1:0] sel_addr;

  always_comb begin
    case (mode[2:0])
      3'd0:    sel_addr = '0;
      3'd1:    sel_addr = dir_rd_addr[0*AW +: AW];
      3'd2:    sel_addr = dir_rd_addr[1*AW +: AW];
      3'd3:    sel_addr = dir_rd_addr[2*AW +: AW];
      3'd4:    sel_addr = dir_rd_addr[3*AW +: AW];
      3'd5:    sel_addr = dir_rd_addr[4*AW +: AW];
      3'd6:    sel_addr = dir_rd_addr[5*AW +: AW];
      default: sel_addr = dir_rd_addr[6*AW +: AW];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_dir  <= 1'b0;
      s1_ind  <= 1'b0;
      s1_sel  <= '0;
      s1_isel <= '0;
      s1_imm  <= '0;
      s1_ye   <= '0;
      s1_addr <= '0;
    end else begin
      s1_dir  <= issue & is_dir;
      s1_ind  <= issue & is_ind;
      s1_sel  <= mode[2:0];
      s1_isel <= mode[1:0];
      s1_imm  <= opnd_lo;
      s1_ye   <= ye;
      s1_addr <= sel_addr;
    end
  end

  assign dir_vld  = s1_dir;
  assign dir_addr = s1_addr;
  always_comb begin
    if (s1_sel == 3'd0) dir_data = s1_imm;
    else                dir_data = dir_rd_data[(32'(s1_sel) - 1) * DW +: DW];
  end

  logic [AW-1:0] p_zp, p_zpx, p_zpy;
  assign p_zp  = {ptr_rd_data[0*DW +: DW], dir_rd_data[0*DW +: DW]};
  assign p_zpx = {ptr_rd_data[1*DW +: DW], dir_rd_data[1*DW +: DW]};
  assign p_zpy = p_zp + {ZPAGE, s1_ye};

  assign ind_rd_addr = {p_zpy, p_zpx, p_zp};

  logic          s2_vld;
  logic [1:0]    s2_sel;
  logic [AW-1:0] s2_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_sel  <= '0;
      s2_addr <= '0;
    end else begin
      s2_vld  <= s1_ind;
      s2_sel  <= s1_isel;
      s2_addr <= ind_rd_addr[32'(s1_isel) * AW +: AW];
    end
  end

  assign ind_vld  = s2_vld;
  assign ind_addr = s2_addr;
  assign ind_data = ind_rd_data[32'(s2_sel) * DW +: DW];

  a_r10_dir_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !mode[3]) |=> dir_vld);
  a_r10_ind_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && mode[3] && mode[2:0] <= 3'd2) |=> ##1 ind_vld);
  a_r10_dir_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dir_vld |-> $past(issue));
  a_r11_ind_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ind_vld |-> $past(issue, 2));
  a_r5_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_vld && s1_sel == 3'd7) |-> (dir_addr[AW-1:DW] == SPAGE));

endmodule

// File: tb/spec_operand_fetch_tb.sv
module spec_operand_fetch_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        issue = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, x_reg = '0, y_reg = '0, sp_reg = '0;
  logic        x_fwd_vld = 1'b0, y_fwd_vld = 1'b0;
  logic [7:0]  x_fwd = '0, y_fwd = '0;
  logic [111:0] dir_rd_addr;
  logic [55:0]  dir_rd_data;
  logic [31:0]  ptr_rd_addr;
  logic [15:0]  ptr_rd_data;
  logic [47:0]  ind_rd_addr;
  logic [23:0]  ind_rd_data;
  logic        dir_vld, ind_vld;
  logic [15:0] dir_addr, ind_addr;
  logic [7:0]  dir_data, ind_data;

  spec_operand_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .mode(mode),
    .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .x_reg(x_reg), .y_reg(y_reg),
    .sp_reg(sp_reg), .x_fwd_vld(x_fwd_vld), .x_fwd(x_fwd),
    .y_fwd_vld(y_fwd_vld), .y_fwd(y_fwd),
    .dir_rd_addr(dir_rd_addr), .dir_rd_data(dir_rd_data),
    .ptr_rd_addr(ptr_rd_addr), .ptr_rd_data(ptr_rd_data),
    .ind_rd_addr(ind_rd_addr), .ind_rd_data(ind_rd_data),
    .dir_vld(dir_vld), .dir_addr(dir_addr), .dir_data(dir_data),
    .ind_vld(ind_vld), .ind_addr(ind_addr), .ind_data(ind_data)
  );

  function automatic logic [7:0] mf(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ (a[15:8] * 8'd5) ^ 8'h1D;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 7; i++) dir_rd_data[i*8 +: 8] <= mf(dir_rd_addr[i*16 +: 16]);
    for (int i = 0; i < 2; i++) ptr_rd_data[i*8 +: 8] <= mf(ptr_rd_addr[i*16 +: 16]);
    for (int i = 0; i < 3; i++) ind_rd_data[i*8 +: 8] <= mf(ind_rd_addr[i*16 +: 16]);
  end

  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ptr_at(input logic [7:0] z);
    return {mf({8'h00, z + 8'd1}), mf({8'h00, z})};
  endfunction

  function automatic logic [15:0] ref_addr(input logic [3:0] m, input logic [7:0] lo, hi, xe, ye, sp);
    case (m)
      4'd0: return 16'h0000;
      4'd1: return {8'h00, lo};
      4'd2: return {8'h00, lo + xe};
      4'd3: return {8'h00, lo + ye};
      4'd4: return {hi, lo};
      4'd5: return {hi, lo} + {8'h00, xe};
      4'd6: return {hi, lo} + {8'h00, ye};
      4'd7: return {8'h01, sp + 8'd1};
      4'd8: return ptr_at(lo);
      4'd9: return ptr_at(lo + xe);
      default: return ptr_at(lo) + {8'h00, ye};
    endcase
  endfunction

  task automatic drive(input logic [3:0] m, input logic [7:0] lo, hi, x, y, sp,
                       input logic fxv, input logic [7:0] fx, input logic fyv, input logic [7:0] fy);
    issue = 1'b1; mode = m; opnd_lo = lo; opnd_hi = hi; x_reg = x; y_reg = y; sp_reg = sp;
    x_fwd_vld = fxv; x_fwd = fx; y_fwd_vld = fyv; y_fwd = fy;
  endtask

  task automatic run_op(input string req, input logic [3:0] m, input logic [7:0] lo, hi, x, y, sp,
                        input logic fxv, input logic [7:0] fx, input logic fyv, input logic [7:0] fy);
    logic [7:0] xe, ye;
    logic [15:0] ea;
    xe = fxv ? fx : x;
    ye = fyv ? fy : y;
    ea = ref_addr(m, lo, hi, xe, ye, sp);
    @(negedge clk);
    drive(m, lo, hi, x, y, sp, fxv, fx, fyv, fy);
    @(negedge clk);
    issue = 1'b0; x_fwd_vld = 1'b0; y_fwd_vld = 1'b0;
    if (m <= 4'd7) begin
      chk({req, " dir_vld"}, dir_vld, 1);
      chk({req, " dir_addr"}, dir_addr, ea);
      chk({req, " dir_data"}, dir_data, (m == 0) ? lo : mf(ea));
      chk({req, " no ind at 1"}, ind_vld, 0);
      @(negedge clk);
      chk({req, " no ind at 2"}, ind_vld, 0);
    end else if (m <= 4'd10) begin
      chk({req, " no dir"}, dir_vld, 0);
      @(negedge clk);
      chk({req, " ind_vld"}, ind_vld, 1);
      chk({req, " ind_addr"}, ind_addr, ea);
      chk({req, " ind_data"}, ind_data, mf(ea));
      chk({req, " no dir at 2"}, dir_vld, 0);
    end else begin
      chk({req, " unused mode dir"}, dir_vld, 0);
      chk({req, " unused mode ind1"}, ind_vld, 0);
      @(negedge clk);
      chk({req, " unused mode ind2"}, ind_vld, 0);
    end
  endtask

  task automatic t_reset;
    chk("R1 dir_vld in reset", dir_vld, 0);
    chk("R1 ind_vld in reset", ind_vld, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dir_vld after reset", dir_vld, 0);
    chk("R1 ind_vld after reset", ind_vld, 0);
  endtask

  task automatic t_imm;
    run_op("R2 imm", 4'd0, 8'h3C, 8'h99, 8'h01, 8'h02, 8'h10, 0, 0, 0, 0);
    run_op("R2 imm zero", 4'd0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic t_zp;
    run_op("R3 zp", 4'd1, 8'h42, 8'h77, 8'h05, 8'h06, 8'h00, 0, 0, 0, 0);
    run_op("R3 zpx wrap", 4'd2, 8'hF0, 8'h77, 8'h20, 8'h06, 8'h00, 0, 0, 0, 0);
    run_op("R3 zpy wrap", 4'd3, 8'hFF, 8'h12, 8'h05, 8'h01, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic t_abs;
    run_op("R4 abs", 4'd4, 8'h34, 8'h12, 8'h05, 8'h06, 8'h00, 0, 0, 0, 0);
    run_op("R4 absx page cross", 4'd5, 8'hF8, 8'h12, 8'h10, 8'h06, 8'h00, 0, 0, 0, 0);
    run_op("R4 absy 64K wrap", 4'd6, 8'hF0, 8'hFF, 8'h05, 8'h20, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic t_stack;
    run_op("R5 stack", 4'd7, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFD, 0, 0, 0, 0);
    run_op("R5 stack wrap", 4'd7, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 0, 0, 0, 0);
  endtask

  task automatic t_ind;
    run_op("R6 (zp)", 4'd8, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0);
    run_op("R6 (zp) ptr wrap", 4'd8, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0);
    run_op("R7 (zp,X)", 4'd9, 8'h20, 8'h00, 8'h13, 8'h00, 8'h00, 0, 0, 0, 0);
    run_op("R7 (zp,X) wrap", 4'd9, 8'hF0, 8'h00, 8'h0F, 8'h00, 8'h00, 0, 0, 0, 0);
    run_op("R8 (zp),Y", 4'd10, 8'h50, 8'h00, 8'h00, 8'hF7, 8'h00, 0, 0, 0, 0);
    run_op("R8 (zp),Y carry", 4'd10, 8'h81, 8'h00, 8'h00, 8'hFF, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic t_fwd;
    run_op("R9 fwd x zpx", 4'd2, 8'h10, 8'h00, 8'h01, 8'h02, 8'h00, 1, 8'h55, 0, 0);
    run_op("R9 fwd y absy", 4'd6, 8'h10, 8'h20, 8'h01, 8'h02, 8'h00, 0, 0, 1, 8'hE0);
    run_op("R9 fwd x (zp,X)", 4'd9, 8'h30, 8'h00, 8'h01, 8'h02, 8'h00, 1, 8'h44, 0, 0);
    run_op("R9 fwd y (zp),Y", 4'd10, 8'h30, 8'h00, 8'h01, 8'h02, 8'h00, 0, 0, 1, 8'hC3);
  endtask

  task automatic t_unused;
    for (int m = 11; m < 16; m++)
      run_op("R10 unused", 4'(m), 8'h12, 8'h34, 8'h01, 8'h02, 8'h03, 0, 0, 0, 0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 10));
      run_op("R10 random mode", m, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
             8'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
    end
  endtask

  task automatic t_b2b(input logic fxv);
    logic [15:0] ea_i, ea_d;
    ea_i = ptr_at(8'h60) + 16'h0009;
    ea_d = {8'h00, 8'h70 + (fxv ? 8'h31 : 8'h03)};
    @(negedge clk);
    drive(4'd10, 8'h60, 8'h00, 8'h02, 8'h09, 8'h00, 0, 0, 0, 0);
    @(negedge clk);
    drive(4'd2, 8'h70, 8'h00, 8'h03, 8'hAA, 8'h00, fxv, 8'h31, fxv, 8'h77);
    @(negedge clk);
    issue = 1'b0; x_fwd_vld = 1'b0; y_fwd_vld = 1'b0;
    chk("R11 both valid dir", dir_vld, 1);
    chk("R11 both valid ind", ind_vld, 1);
    chk("R11 ind addr", ind_addr, ea_i);
    chk("R11 ind data", ind_data, mf(ea_i));
    chk("R11 dir addr", dir_addr, ea_d);
    chk("R11 dir data", dir_data, mf(ea_d));
    @(negedge clk);
    chk("R11 idle after", {dir_vld, ind_vld}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_imm();
    t_zp();
    t_abs();
    t_stack();
    t_ind();
    t_fwd();
    t_unused();
    t_b2b(0);
    t_b2b(1);
    t_random();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule